// File: doc/BRIEF.md
# Pipelined Burst Memory Access Controller

This block is the synchronous front end of a small pipelined burst memory. Every control and data input is captured on the rising clock edge. An access begins when one of two address strobes is seen low. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. Once a burst is open, each cycle with no strobe continues it. A low advance input steps a two-bit beat counter, and a high advance input repeats the current address.

The beat address keeps the upper address bits of the starting address. Its low two bits are the starting low bits XORed with the counter, so the beats follow an interleaved order that wraps after the fourth beat. Writes go into a byte-lane register array. Reads leave through an array read register and then an output register, and the output carries a separate drive-enable for a tri-state pad. An asynchronous sleep input clears the pipeline and the open burst at once and keeps the array contents.

Top module: `pburst_sram`

## Requirements
- R1: While reset is asserted and after it is released with no access started, `rdata_en` is low.
- R2: The part is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe seen with any other combination starts nothing, closes any open burst and produces no read data.
- R3: A low `cpu_stb_n` with the part selected starts a read burst at `addr_i`. The write controls are ignored in that cycle, so the array is left unchanged.
- R4: A low `ctl_stb_n` with `cpu_stb_n` high and the part selected starts a burst at `addr_i`. It is a write if any lane is enabled for writing and a read otherwise.
- R5: Read data captured at clock edge k is driven, with `rdata_en` high, from edge k+2 onward.
- R6: In a continuation cycle (both strobes high, burst open) with `step_n`=0, the beat counter steps by one. The beat address is the starting address with its low two bits XORed with the counter 0,1,2,3, and the counter wraps to 0 after 3.
- R7: In a continuation cycle with `step_n`=1, the counter holds and the access repeats the current address.
- R8: Continuation cycles with write lanes enabled write `wdata` at the current beat address, so write bursts follow the same order as read bursts.
- R9: Lane i covers `wdata[8i+7:8i]`. `wr_all_n`=0 enables every lane. Otherwise `bwr_n`=0 enables each lane whose `lane_n[i]` is 0. With `bwr_n`=0 and all `lane_n` high the cycle is a read.
- R10: After a write cycle, continuation cycles with no write enabled produce no read data (`rdata_en` stays low) until a strobe starts a new read.
- R11: `rdata_en` is high only while `out_en_n` is low. `out_en_n` acts in the same cycle, with no clock edge.
- R12: Raising `sleep_i` drops `rdata_en` at once, with no clock edge, and clears the pipeline and the open burst. After release the output stays low until a new read is started, and the array contents written before sleep are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| addr_i | input | AW | Starting address presented with a strobe |
| sel_a_n | input | 1 | Select term, active low |
| sel_b | input | 1 | Select term, active high |
| sel_c_n | input | 1 | Select term, active low |
| cpu_stb_n | input | 1 | Processor-side address strobe, starts reads |
| ctl_stb_n | input | 1 | Controller-side address strobe, starts reads or writes |
| step_n | input | 1 | Burst advance, low steps the counter |
| wr_all_n | input | 1 | Write all lanes, active low |
| bwr_n | input | 1 | Lane-select write enable, active low |
| lane_n | input | NB | Per-lane write selects, active low |
| out_en_n | input | 1 | Output drive enable, active low |
| wdata | input | NB*BW | Write data |
| rdata | output | NB*BW | Registered read data |
| rdata_en | output | 1 | Tri-state drive enable for `rdata` |

## Verification
The hardest state to reach is sleep asserted in the middle of a held read burst. At that moment the pipeline is full and the output is driving, and the check is that the output drops without a clock edge and that no later continuation cycle brings it back. The stimulus first fills the array with interleaved write bursts, then opens a read burst and holds it with the advance input high until data is on the output. Sleep is raised between clock edges at that point. A quieter case is the high-Z state after a write burst, which only shows when continuation reads follow writes without a strobe. The bench sets this up by ending a byte-lane write burst with plain advance cycles.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    // Kind of access captured in the input register stage
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

endpackage

// File: rtl/pbs_wr_decode.sv
module pbs_wr_decode #(
    parameter int NB = 4
) (
    input  logic          wr_all_n,
    input  logic          bwr_n,
    input  logic [NB-1:0] lane_n,
    output logic [NB-1:0] be_o,
    output logic          wr_o
);

    // One enable per byte lane: a global write covers every lane,
    // a lane-select write covers only the selected lanes.
    generate
        for (genvar g = 0; g < NB; g++) begin : g_lane
            assign be_o[g] = !wr_all_n || (!bwr_n && !lane_n[g]);
        end
    endgenerate

    assign wr_o = |be_o;

endmodule

// File: rtl/pbs_addr_gen.sv
module pbs_addr_gen #(
    parameter int AW = 6,
    parameter int CW = 2
) (
    input  logic          clk_i,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] load_addr_i,
    output logic [AW-1:0] acc_addr_o
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
    } ag_t;

    ag_t           s_q;
    ag_t           s_d;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        s_d    = s_q;
        cnt_nx = step_i ? (s_q.cnt + CW'(1)) : s_q.cnt;
        // Interleaved order: low bits of the start XOR beat number
        acc_addr_o = {s_q.base[AW-1:CW], s_q.base[CW-1:0] ^ cnt_nx};
        if (load_i) begin
            s_d.base   = load_addr_i;
            s_d.cnt    = '0;
            acc_addr_o = load_addr_i;
        end else begin
            s_d.cnt = cnt_nx;
        end
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) s_q <= '0;
        else       s_q <= s_d;
    end

    // R6
    step_moves_low_bits_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        (step_i && !load_i) |->
            (acc_addr_o[AW-1:CW] == $past(acc_addr_o[AW-1:CW]) &&
             acc_addr_o[CW-1:0] != $past(acc_addr_o[CW-1:0])));

    // R7
    hold_keeps_addr_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        (!step_i && !load_i) |-> acc_addr_o == $past(acc_addr_o));

endmodule

// File: rtl/pbs_array.sv
module pbs_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic             re_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [NB-1:0]    be_i,
    input  logic [NB*BW-1:0] wdata_i,
    output logic [NB*BW-1:0] rdata_o,
    output logic             rvalid_o
);

    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          v;
        logic [DW-1:0] d;
    } rd_t;

    rd_t           r_q;
    rd_t           r_d;
    logic [DW-1:0] rd_word;

    // One storage column per byte lane, written only when its enable is set
    generate
        for (genvar g = 0; g < NB; g++) begin : g_col
            logic [BW-1:0] mem [DEPTH];
            always_ff @(posedge clk_i) begin
                if (we_i && be_i[g]) mem[addr_i] <= wdata_i[g*BW +: BW];
            end
            assign rd_word[g*BW +: BW] = mem[addr_i];
        end
    endgenerate

    always_comb begin
        r_d   = r_q;
        r_d.v = re_i;
        if (re_i) r_d.d = rd_word;
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign rdata_o  = r_q.d;
    assign rvalid_o = r_q.v;

    // R10
    write_gives_no_read_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        we_i |=> !rvalid_o);

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
    parameter int AW         = 6,
    parameter int NB         = 4,
    parameter int BW         = 8,
    parameter int BURST_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             bwr_n,
    input  logic [NB-1:0]    lane_n,
    input  logic             out_en_n,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata,
    output logic             rdata_en
);

    import pbs_pkg::*;

    localparam int DW = NB * BW;

    typedef struct packed {
        op_e           op;      // captured access kind
        logic [AW-1:0] addr;    // captured beat address
        logic [NB-1:0] be;      // captured lane enables
        logic [DW-1:0] wdata;   // captured write data
        logic          active;  // a burst is open
        logic          rd_ok;   // continuation cycles may read
        logic          out_v;   // output register holds read data
        logic [DW-1:0] out_d;   // output register
    } st_t;

    st_t s_q;
    st_t s_d;

    logic          hold_clr;
    logic          sel;
    logic          cpu_go;
    logic          strobe;
    logic          load;
    logic          step;
    logic [NB-1:0] be;
    logic          wr;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] arr_rd;
    logic          arr_rv;

    assign hold_clr = !rst_n || sleep_i;
    assign sel      = !sel_a_n && sel_b && !sel_c_n;
    assign cpu_go   = !cpu_stb_n;
    assign strobe   = cpu_go || !ctl_stb_n;
    assign load     = strobe && sel && !hold_clr;
    assign step     = !strobe && s_q.active && !step_n && !hold_clr;

    pbs_wr_decode #(.NB(NB)) u_wdec (
        .wr_all_n (wr_all_n),
        .bwr_n    (bwr_n),
        .lane_n   (lane_n),
        .be_o     (be),
        .wr_o     (wr)
    );

    pbs_addr_gen #(.AW(AW), .CW(BURST_BITS)) u_agen (
        .clk_i       (clk),
        .clr_i       (hold_clr),
        .load_i      (load),
        .step_i      (step),
        .load_addr_i (addr_i),
        .acc_addr_o  (acc_addr)
    );

    pbs_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
        .clk_i    (clk),
        .clr_i    (hold_clr),
        .we_i     (s_q.op == OP_WR),
        .re_i     (s_q.op == OP_RD),
        .addr_i   (s_q.addr),
        .be_i     (s_q.be),
        .wdata_i  (s_q.wdata),
        .rdata_o  (arr_rd),
        .rvalid_o (arr_rv)
    );

    always_comb begin
        s_d       = s_q;
        s_d.op    = OP_IDLE;
        s_d.addr  = acc_addr;
        s_d.be    = be;
        s_d.wdata = wdata;
        if (strobe) begin
            if (sel) begin
                s_d.active = 1'b1;
                if (cpu_go || !wr) begin
                    // processor strobe ignores write controls
                    s_d.op    = OP_RD;
                    s_d.be    = '0;
                    s_d.rd_ok = 1'b1;
                end else begin
                    s_d.op    = OP_WR;
                    s_d.rd_ok = 1'b0;
                end
            end else begin
                s_d.active = 1'b0;
                s_d.rd_ok  = 1'b0;
            end
        end else if (s_q.active) begin
            if (wr) begin
                s_d.op    = OP_WR;
                s_d.rd_ok = 1'b0;
            end else if (s_q.rd_ok) begin
                s_d.op = OP_RD;
                s_d.be = '0;
            end
        end
        // output register stage
        s_d.out_v = arr_rv;
        if (arr_rv) s_d.out_d = arr_rd;
    end

    always_ff @(posedge clk or posedge hold_clr) begin
        if (hold_clr) s_q <= '0;
        else          s_q <= s_d;
    end

    assign rdata    = s_q.out_d;
    assign rdata_en = s_q.out_v && !out_en_n && !sleep_i;

    // R5
    read_two_stage_chk: assert property (@(posedge clk) disable iff (hold_clr)
        (s_q.op == OP_RD) |=> ##1 s_q.out_v);

    // R10
    write_keeps_hiz_chk: assert property (@(posedge clk) disable iff (hold_clr)
        (s_q.op == OP_WR) |=> ##1 !s_q.out_v);

    // R2
    deselect_closes_chk: assert property (@(posedge clk) disable iff (hold_clr)
        (strobe && !sel) |=> (s_q.op == OP_IDLE && !s_q.active));

    // R12
    sleep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (!s_q.out_v && !s_q.active && !rdata_en));

endmodule

// File: tb/pburst_sram_test.sv
module pburst_sram_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic        cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, step_n = 1'b1;
    logic        wr_all_n = 1'b1, bwr_n = 1'b1;
    logic [3:0]  lane_n = 4'hF;
    logic        out_en_n = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdata_en;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] mm [64];
    bit          m_act = 0, m_rdok = 0;
    int          m_base = 0, m_cnt = 0;
    bit          s0_v = 0, s1_v = 0, o_v = 0;
    logic [31:0] s0_d = '0, s1_d = '0, o_d = '0;

    pburst_sram uut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .addr_i(addr_i),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .bwr_n(bwr_n), .lane_n(lane_n),
        .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(int i);
        return {8'(i), 8'(i ^ 'h5A), 8'(i + 3), 8'(255 - i)};
    endfunction

    task automatic model_clear();
        m_act = 0; m_rdok = 0; m_cnt = 0; m_base = 0;
        s0_v = 0; s1_v = 0; o_v = 0;
    endtask

    always @(negedge rst_n or posedge sleep_i) model_clear();

    always @(posedge clk) begin
        if (rst_n && !sleep_i) begin
            bit          sel, wr;
            int          op, a;
            logic [3:0]  be;
            logic [31:0] rd;
            sel = !sel_a_n && sel_b && !sel_c_n;
            for (int i = 0; i < 4; i++) be[i] = !wr_all_n || (!bwr_n && !lane_n[i]);
            wr = (be != 0);
            op = 0; a = 0; rd = '0;
            if (!cpu_stb_n || !ctl_stb_n) begin
                if (sel) begin
                    m_base = int'(addr_i); m_cnt = 0; m_act = 1; a = m_base;
                    if (!cpu_stb_n || !wr) begin op = 1; m_rdok = 1; end
                    else begin op = 2; m_rdok = 0; end
                end else begin
                    m_act = 0; m_rdok = 0;
                end
            end else if (m_act) begin
                if (!step_n) m_cnt = (m_cnt + 1) % 4;
                a = (m_base & ~3) | ((m_base ^ m_cnt) & 3);
                if (wr) begin op = 2; m_rdok = 0; end
                else if (m_rdok) op = 1;
            end
            if (op == 1) rd = mm[a];
            if (op == 2)
                for (int i = 0; i < 4; i++) if (be[i]) mm[a][8*i +: 8] = wdata[8*i +: 8];
            o_v = s1_v; o_d = s1_d;
            s1_v = s0_v; s1_d = s0_d;
            s0_v = (op == 1); s0_d = rd;
        end
    end

    // per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            bit exp_en;
            exp_en = o_v && !out_en_n && !sleep_i;
            checks++;
            if (rdata_en !== exp_en) begin
                errors++;
                $display("FAIL %s: rdata_en actual %b expected %b", cur_req, rdata_en, exp_en);
            end else if (exp_en && rdata !== o_d) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", cur_req, rdata, o_d);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #3;
    endtask

    task automatic idle_in();
        cpu_stb_n = 1; ctl_stb_n = 1; step_n = 1; wr_all_n = 1; bwr_n = 1;
        lane_n = 4'hF; sel_a_n = 0; sel_b = 1; sel_c_n = 0; wdata = '0;
    endtask

    task automatic deselect();
        idle_in(); ctl_stb_n = 0; sel_a_n = 1;
    endtask

    task automatic chk_en(string req, logic exp);
        checks++;
        if (rdata_en !== exp) begin
            errors++;
            $display("FAIL %s: rdata_en actual %b expected %b", req, rdata_en, exp);
        end
    endtask

    task automatic chk_rd(string req, logic [31:0] exp);
        checks++;
        if (rdata_en !== 1'b1 || rdata !== exp) begin
            errors++;
            $display("FAIL %s: en/data actual %b/%h expected 1/%h", req, rdata_en, rdata, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] e20, e21;
        for (int i = 0; i < 64; i++) mm[i] = '0;
        idle_in();
        #2; chk_en("R1", 1'b0);
        repeat (3) cyc();
        rst_n = 1;
        cyc(); chk_en("R1", 1'b0);
        cyc(); chk_en("R1", 1'b0);

        // fill the array with interleaved write bursts (R8)
        cur_req = "R8";
        for (int b = 0; b < 64; b += 4) begin
            idle_in(); ctl_stb_n = 0; addr_i = 6'(b); wr_all_n = 0; wdata = pat(b); cyc();
            for (int c = 1; c < 4; c++) begin
                idle_in(); step_n = 0; wr_all_n = 0; wdata = pat(b ^ c); cyc();
            end
        end
        idle_in(); cyc(); chk_en("R10", 1'b0);
        cyc(); chk_en("R10", 1'b0);

        // latency of a single read (R5)
        cur_req = "R5";
        idle_in(); ctl_stb_n = 0; addr_i = 12; cyc(); chk_en("R5", 1'b0);
        deselect(); cyc(); chk_en("R5", 1'b0);
        idle_in(); cyc(); chk_rd("R5", pat(12));
        cyc(); chk_en("R2", 1'b0);

        // processor-strobe read with write controls active, interleave, wrap, hold
        cur_req = "R6";
        idle_in(); cpu_stb_n = 0; addr_i = 5; wr_all_n = 0; wdata = '0; cyc();
        idle_in(); step_n = 0; cyc();
        cyc(); chk_rd("R3", pat(5));
        cyc(); chk_rd("R6", pat(4));
        cyc(); chk_rd("R6/R8", pat(7));
        idle_in(); cur_req = "R7"; cyc(); chk_rd("R6", pat(6));
        cyc(); chk_rd("R6", pat(5));
        cyc(); chk_rd("R7", pat(5));
        cyc(); chk_rd("R7", pat(5));
        deselect(); cyc();
        idle_in(); repeat (3) cyc();
        chk_en("R2", 1'b0);

        // lane writes through the controller strobe, then silent continuation
        cur_req = "R9";
        idle_in(); ctl_stb_n = 0; addr_i = 20; bwr_n = 0; lane_n = 4'b1010;
        wdata = 32'hDEADBEEF; cyc();
        idle_in(); step_n = 0; bwr_n = 0; lane_n = 4'b0101; wdata = 32'h12345678; cyc();
        cur_req = "R10";
        idle_in(); step_n = 0; cyc(); chk_en("R10", 1'b0);
        cyc(); chk_en("R10", 1'b0);
        cyc(); chk_en("R10", 1'b0);
        e20 = (pat(20) & 32'hFF00FF00) | (32'hDEADBEEF & 32'h00FF00FF);
        e21 = (pat(21) & 32'h00FF00FF) | (32'h12345678 & 32'hFF00FF00);
        idle_in(); cpu_stb_n = 0; addr_i = 20; cyc();
        idle_in(); step_n = 0; cyc();
        idle_in(); cyc(); chk_rd("R9", e20);
        cyc(); chk_rd("R9", e21);
        deselect(); cyc();

        // lane-select write with no lane chosen is a read (R4, R9)
        cur_req = "R4";
        idle_in(); ctl_stb_n = 0; addr_i = 22; bwr_n = 0; lane_n = 4'hF; wdata = '1; cyc();
        deselect(); cyc();
        idle_in(); cyc(); chk_rd("R4", pat(22));
        idle_in(); ctl_stb_n = 0; addr_i = 23; wr_all_n = 0; wdata = 32'hCAFEF00D; cyc();
        deselect(); cyc();
        idle_in(); cyc(); chk_en("R4", 1'b0);

        // select combinations that do not select the part (R2)
        cur_req = "R2";
        for (int k = 0; k < 3; k++) begin
            idle_in(); ctl_stb_n = 0; addr_i = 3;
            if (k == 0) sel_a_n = 1; else if (k == 1) sel_b = 0; else sel_c_n = 1;
            cyc();
            idle_in(); cyc(); cyc(); chk_en("R2", 1'b0);
        end

        // output enable acts without a clock edge (R11)
        cur_req = "R11";
        idle_in(); cpu_stb_n = 0; addr_i = 30; cyc();
        idle_in(); cyc(); cyc(); chk_rd("R11", pat(30));
        out_en_n = 1; #1; chk_en("R11", 1'b0);
        cyc(); chk_en("R11", 1'b0);
        out_en_n = 0; #1; chk_rd("R11", pat(30));

        // sleep in the middle of a held read burst (R12)
        cur_req = "R12";
        sleep_i = 1; #1; chk_en("R12", 1'b0);
        cyc(); cyc(); chk_en("R12", 1'b0);
        sleep_i = 0;
        cyc(); cyc(); cyc(); chk_en("R12", 1'b0);
        idle_in(); cpu_stb_n = 0; addr_i = 23; cyc();
        deselect(); cyc();
        idle_in(); cyc(); chk_rd("R12", 32'hCAFEF00D);
        cyc();

        done = 1;
        summary();
        $finish;
    end

endmodule